// File: doc/BRIEF.md
# Chipset control register file

This block is the software-visible control store of a system chipset. It is a bank of 32-bit registers behind a simple request/response bus that accepts byte, halfword and word accesses. The bank holds a global configuration word, a pair of DMA translation window registers (base and limit), fifteen remote-speed registers, an eight-channel DMA descriptor array with four words per channel, an I/O cache byte-mask register with special access rules, and a handful of fixed or miscellaneous registers.

A narrow write changes only the addressed lane: the current word is read, the lane is replaced, and the whole word is written back. A narrow read returns the addressed lane in the low bits of the response. The request side has no ready signal. The bank accepts a request on every cycle that `req_valid` is high, so it never applies back-pressure. Each request gets exactly one response cycle on the next clock.

Top module: `csr_bank`

## Requirements
- R1: After a synchronous active-high reset, these registers hold these values: offset 0x000 holds 0x00000104 (memory-size code 1 in bits 9:8, bit 2 set), 0x210 holds 0x00018186, 0x220 and 0x238 read 0x00000007, and each remote-speed register holds 0x00000007. Every other register reads 0, including the byte-mask register.
- R2: `rsp_valid` is high in the cycle after each cycle with `req_valid` high, and low otherwise. For a read, `rsp_rdata` carries the read result. For a write, `rsp_rdata` is 0.
- R3: Size code 0 is a byte access: the lane is `req_addr[1:0]` and the data is `req_wdata[7:0]`. Size code 1 is a halfword access: the lane is `req_addr[1]` and the data is `req_wdata[15:0]`. Size codes 2 and 3 are word accesses, and `req_addr[1:0]` is ignored. A narrow write leaves the other lanes of the word unchanged.
- R4: A narrow read returns the addressed lane in the low bits of `rsp_rdata` and zeros above it.
- R5: Fifteen read/write remote-speed registers sit at 0x070 + 8*k, for k = 0..14. The words in between (for example 0x074) and 0x0E8 are unmapped.
- R6: The DMA descriptor words sit at 0x100 + 32*channel + 8*word, for channel 0..7 and word 0..3. Each is an independent read/write register. Odd word offsets such as 0x104 are unmapped.
- R7: A write to the byte-mask register (0x058) ORs the merged write word into its current value, so bits are never cleared by a write.
- R8: A read of 0x058 returns its value. If that value was all ones, the register becomes 0 after the read. Any other value is kept.
- R9: Offsets 0x010, 0x038, 0x040 and 0x208 always read 0, and 0x220 and 0x238 always read 7. Writes to any of these six change nothing.
- R10: Offsets 0x048, 0x050 and 0x060 accept writes but always read 0.
- R11: A read of an unmapped offset (for example 0x228 or 0x300) returns 0. A write to an unmapped offset changes no register.
- R12: Offsets 0x000, 0x018, 0x020 and 0x210 are plain read/write registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present; accepted every cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| req_addr | input | 14 | Byte offset into the bank |
| req_wdata | input | 32 | Write data, narrow data in the low bits |
| rsp_valid | output | 1 | Response valid, one cycle after the request |
| rsp_rdata | output | 32 | Read data (0 for writes) |

## Verification
A register that holds a wrong value stays invisible until software reads it. A read response shows the error exactly one cycle after the request, so the bench reads back every register it writes, and also reads back neighbours it did not write, to catch decode aliasing. The byte-mask register carries hidden history: a missing OR or a missing clear only shows on the second read that follows. The bench therefore checks a pair of reads wherever the mask's history matters. Response-timing errors show on `rsp_valid` within one cycle of any request or idle cycle.

// File: rtl/csr_bank_pkg.sv
package csr_bank_pkg;
  localparam int DATA_W = 32;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WALT = 2'd3
  } acc_size_e;

  typedef enum logic [3:0] {
    RG_NONE,
    RG_CFG,
    RG_XBASE,
    RG_XLIM,
    RG_MASK,
    RG_SPEED,
    RG_DESC,
    RG_MISC,
    RG_ZERO_RO,
    RG_SEVEN_RO,
    RG_SINK
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e  kind;
    logic [7:0] idx;
  } dec_t;

  localparam logic [DATA_W-1:0] CFG_RST   = 32'h0000_0104;
  localparam logic [DATA_W-1:0] MISC_RST  = 32'h0001_8186;
  localparam logic [DATA_W-1:0] SPEED_RST = 32'h0000_0007;
  localparam logic [DATA_W-1:0] SEVEN     = 32'h0000_0007;
endpackage

// File: rtl/csr_addr_decode.sv
module csr_addr_decode
  import csr_bank_pkg::*;
#(
  parameter int ADDR_W    = 14,
  parameter int SPEED_N   = 15,
  parameter int DESC_CH   = 8,
  parameter int DESC_REGS = 4
) (
  input  logic [ADDR_W-1:0] addr,
  output dec_t              dec,
  output logic              hit
);
  localparam logic [ADDR_W-1:0] SPEED_BASE = ADDR_W'('h070);
  localparam logic [ADDR_W-1:0] SPEED_SPAN = ADDR_W'(8 * SPEED_N);
  localparam logic [ADDR_W-1:0] DESC_BASE  = ADDR_W'('h100);
  localparam logic [ADDR_W-1:0] DESC_SPAN  = ADDR_W'(8 * DESC_CH * DESC_REGS);

  logic [ADDR_W-1:0] w;
  logic [ADDR_W-1:0] sp_off;
  logic [ADDR_W-1:0] ds_off;

  assign w      = {addr[ADDR_W-1:2], 2'b00};
  assign sp_off = w - SPEED_BASE;
  assign ds_off = w - DESC_BASE;

  always_comb begin
    dec.kind = RG_NONE;
    dec.idx  = '0;
    case (w)
      ADDR_W'('h000): dec.kind = RG_CFG;
      ADDR_W'('h018): dec.kind = RG_XBASE;
      ADDR_W'('h020): dec.kind = RG_XLIM;
      ADDR_W'('h058): dec.kind = RG_MASK;
      ADDR_W'('h210): dec.kind = RG_MISC;
      ADDR_W'('h010), ADDR_W'('h038),
      ADDR_W'('h040), ADDR_W'('h208): dec.kind = RG_ZERO_RO;
      ADDR_W'('h220), ADDR_W'('h238): dec.kind = RG_SEVEN_RO;
      ADDR_W'('h048), ADDR_W'('h050),
      ADDR_W'('h060): dec.kind = RG_SINK;
      default: begin
        // R5: 8-byte stride, only even word slots
        if (w >= SPEED_BASE && sp_off < SPEED_SPAN && !w[2]) begin
          dec.kind = RG_SPEED;
          dec.idx  = 8'(sp_off >> 3);
        // R6: flat index = channel*DESC_REGS + word
        end else if (w >= DESC_BASE && ds_off < DESC_SPAN && !w[2]) begin
          dec.kind = RG_DESC;
          dec.idx  = 8'(ds_off >> 3);
        end
      end
    endcase
  end

  assign hit = (dec.kind != RG_NONE);
endmodule

// File: rtl/csr_lane_align.sv
module csr_lane_align
  import csr_bank_pkg::*;
(
  input  acc_size_e         size,
  input  logic [1:0]        lane,
  input  logic [DATA_W-1:0] cur_word,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] merged,
  output logic [DATA_W-1:0] rd_lane
);
  // R3 write merge, R4 read extract
  always_comb begin
    merged  = cur_word;
    rd_lane = cur_word;
    case (size)
      SZ_BYTE: begin
        merged[8*lane +: 8] = wdata[7:0];
        rd_lane = {24'b0, cur_word[8*lane +: 8]};
      end
      SZ_HALF: begin
        merged[16*lane[1] +: 16] = wdata[15:0];
        rd_lane = {16'b0, cur_word[16*lane[1] +: 16]};
      end
      default: begin
        merged  = wdata;
        rd_lane = cur_word;
      end
    endcase
  end
endmodule

// File: rtl/csr_bank.sv
module csr_bank
  import csr_bank_pkg::*;
#(
  parameter int ADDR_W    = 14,
  parameter int SPEED_N   = 15,
  parameter int DESC_CH   = 8,
  parameter int DESC_REGS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);
  localparam int DESC_N = DESC_CH * DESC_REGS;

  dec_t              dec;
  logic              dec_hit;
  logic [DATA_W-1:0] cur_word, merged, rd_lane;
  logic [DATA_W-1:0] cfg_q, xbase_q, xlim_q, mask_q, misc_q;
  logic [DATA_W-1:0] speed_q [SPEED_N];
  logic [DATA_W-1:0] desc_q  [DESC_N];
  logic [DATA_W-1:0] speed_rd, desc_rd;
  logic              wr, rd;

  assign wr = req_valid & req_write;
  assign rd = req_valid & ~req_write;

  csr_addr_decode #(
    .ADDR_W(ADDR_W), .SPEED_N(SPEED_N), .DESC_CH(DESC_CH), .DESC_REGS(DESC_REGS)
  ) u_dec (
    .addr(req_addr), .dec(dec), .hit(dec_hit)
  );

  always_comb begin
    speed_rd = '0;
    for (int i = 0; i < SPEED_N; i++)
      if (dec.idx == 8'(i)) speed_rd = speed_q[i];
    desc_rd = '0;
    for (int i = 0; i < DESC_N; i++)
      if (dec.idx == 8'(i)) desc_rd = desc_q[i];
  end

  // R9 R10 R11: constants, sinks and holes read through this mux
  always_comb begin
    case (dec.kind)
      RG_CFG:      cur_word = cfg_q;
      RG_XBASE:    cur_word = xbase_q;
      RG_XLIM:     cur_word = xlim_q;
      RG_MASK:     cur_word = mask_q;
      RG_MISC:     cur_word = misc_q;
      RG_SPEED:    cur_word = speed_rd;
      RG_DESC:     cur_word = desc_rd;
      RG_SEVEN_RO: cur_word = SEVEN;
      default:     cur_word = '0;
    endcase
  end

  csr_lane_align u_lane (
    .size(acc_size_e'(req_size)), .lane(req_addr[1:0]), .cur_word(cur_word),
    .wdata(req_wdata), .merged(merged), .rd_lane(rd_lane)
  );

  // R1 R12 R7 R8: scalar registers
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q   <= CFG_RST;
      xbase_q <= '0;
      xlim_q  <= '0;
      mask_q  <= '0;
      misc_q  <= MISC_RST;
    end else if (wr) begin
      case (dec.kind)
        RG_CFG:   cfg_q   <= merged;
        RG_XBASE: xbase_q <= merged;
        RG_XLIM:  xlim_q  <= merged;
        RG_MASK:  mask_q  <= mask_q | merged;
        RG_MISC:  misc_q  <= merged;
        default:  ;
      endcase
    end else if (rd && dec.kind == RG_MASK && mask_q == '1) begin
      mask_q <= '0;
    end
  end

  // R5: remote-speed registers
  for (genvar g = 0; g < SPEED_N; g++) begin : g_speed
    always_ff @(posedge clk) begin
      if (rst) speed_q[g] <= SPEED_RST;
      else if (wr && dec.kind == RG_SPEED && dec.idx == 8'(g)) speed_q[g] <= merged;
    end
  end

  // R6: DMA descriptor words
  for (genvar g = 0; g < DESC_N; g++) begin : g_desc
    always_ff @(posedge clk) begin
      if (rst) desc_q[g] <= '0;
      else if (wr && dec.kind == RG_DESC && dec.idx == 8'(g)) desc_q[g] <= merged;
    end
  end

  // R2: one-cycle registered response
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_rdata <= rd ? rd_lane : '0;
    end
  end
endmodule

// File: rtl/csr_bank_chk.sv
module csr_bank_chk #(
  parameter int ADDR_W = 14
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_write,
  input logic [1:0]        req_size,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rsp_valid,
  input logic [31:0]       rsp_rdata,
  input logic [31:0]       mask_q,
  input logic              hit
);
  logic [ADDR_W-1:0] wa;
  assign wa = {req_addr[ADDR_W-1:2], 2'b00};

  // R2
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  // R2
  rsp_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);

  // R7
  mask_keeps_bits_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && wa == ADDR_W'('h058))
      |=> ((mask_q & $past(mask_q)) == $past(mask_q)));

  // R8
  mask_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write && wa == ADDR_W'('h058) && mask_q == 32'hFFFF_FFFF)
      |=> (mask_q == 32'h0));

  // R11
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write && !hit) |=> (rsp_rdata == 32'h0));

  // R9
  seven_const_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write && req_size == 2'd2 && wa == ADDR_W'('h220))
      |=> (rsp_rdata == 32'h7));
endmodule

bind csr_bank csr_bank_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
  .req_size(req_size), .req_addr(req_addr), .rsp_valid(rsp_valid),
  .rsp_rdata(rsp_rdata), .mask_q(mask_q), .hit(dec_hit)
);

// File: tb/csr_bank_tb.sv
module csr_bank_tb;
  localparam int AW = 14;
  localparam int N  = 48;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_write = 1'b0;
  logic [1:0]    req_size = 2'd2;
  logic [AW-1:0] req_addr = '0;
  logic [31:0]   req_wdata = '0;
  logic          rsp_valid;
  logic [31:0]   rsp_rdata;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  csr_bank u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  // {req[3:0], write, size[1:0], addr[13:0], wdata[31:0], expect[31:0]}
  localparam logic [84:0] VEC [N] = '{
    {4'd1,  1'b0, 2'd2, 14'h000, 32'h0,         32'h0000_0104}, // R1
    {4'd1,  1'b0, 2'd2, 14'h210, 32'h0,         32'h0001_8186}, // R1
    {4'd1,  1'b0, 2'd2, 14'h220, 32'h0,         32'h0000_0007}, // R1
    {4'd1,  1'b0, 2'd2, 14'h238, 32'h0,         32'h0000_0007}, // R1
    {4'd1,  1'b0, 2'd2, 14'h070, 32'h0,         32'h0000_0007}, // R1
    {4'd1,  1'b0, 2'd2, 14'h0E0, 32'h0,         32'h0000_0007}, // R1
    {4'd1,  1'b0, 2'd2, 14'h1E8, 32'h0,         32'h0000_0000}, // R1
    {4'd12, 1'b1, 2'd2, 14'h000, 32'hDEAD_BEEF, 32'h0},         // R12
    {4'd12, 1'b0, 2'd2, 14'h000, 32'h0,         32'hDEAD_BEEF}, // R12
    {4'd3,  1'b1, 2'd0, 14'h001, 32'h0000_0055, 32'h0},         // R3
    {4'd3,  1'b0, 2'd2, 14'h000, 32'h0,         32'hDEAD_55EF}, // R3
    {4'd3,  1'b1, 2'd1, 14'h002, 32'h0000_1234, 32'h0},         // R3
    {4'd3,  1'b0, 2'd2, 14'h000, 32'h0,         32'h1234_55EF}, // R3
    {4'd4,  1'b0, 2'd0, 14'h003, 32'h0,         32'h0000_0012}, // R4
    {4'd4,  1'b0, 2'd1, 14'h000, 32'h0,         32'h0000_55EF}, // R4
    {4'd4,  1'b0, 2'd0, 14'h001, 32'h0,         32'h0000_0055}, // R4
    {4'd5,  1'b1, 2'd2, 14'h078, 32'hA5A5_A5A5, 32'h0},         // R5
    {4'd5,  1'b0, 2'd2, 14'h078, 32'h0,         32'hA5A5_A5A5}, // R5
    {4'd5,  1'b0, 2'd2, 14'h070, 32'h0,         32'h0000_0007}, // R5
    {4'd5,  1'b0, 2'd2, 14'h074, 32'h0,         32'h0},         // R5
    {4'd5,  1'b0, 2'd2, 14'h0E8, 32'h0,         32'h0},         // R5
    {4'd6,  1'b1, 2'd2, 14'h1F8, 32'hCAFE_0001, 32'h0},         // R6
    {4'd6,  1'b1, 2'd2, 14'h100, 32'h1111_1111, 32'h0},         // R6
    {4'd6,  1'b0, 2'd2, 14'h1F8, 32'h0,         32'hCAFE_0001}, // R6
    {4'd6,  1'b0, 2'd2, 14'h100, 32'h0,         32'h1111_1111}, // R6
    {4'd6,  1'b0, 2'd2, 14'h108, 32'h0,         32'h0},         // R6
    {4'd9,  1'b1, 2'd2, 14'h010, 32'hFFFF_FFFF, 32'h0},         // R9
    {4'd9,  1'b0, 2'd2, 14'h010, 32'h0,         32'h0},         // R9
    {4'd9,  1'b1, 2'd2, 14'h220, 32'h0,         32'h0},         // R9
    {4'd9,  1'b0, 2'd2, 14'h220, 32'h0,         32'h0000_0007}, // R9
    {4'd10, 1'b1, 2'd2, 14'h048, 32'h1234_5678, 32'h0},         // R10
    {4'd10, 1'b0, 2'd2, 14'h048, 32'h0,         32'h0},         // R10
    {4'd11, 1'b1, 2'd2, 14'h228, 32'h0000_FFFF, 32'h0},         // R11
    {4'd11, 1'b0, 2'd2, 14'h228, 32'h0,         32'h0},         // R11
    {4'd11, 1'b0, 2'd2, 14'h300, 32'h0,         32'h0},         // R11
    {4'd12, 1'b1, 2'd2, 14'h210, 32'h0000_ABCD, 32'h0},         // R12
    {4'd12, 1'b0, 2'd2, 14'h210, 32'h0,         32'h0000_ABCD}, // R12
    {4'd7,  1'b1, 2'd2, 14'h058, 32'h0F0F_0F0F, 32'h0},         // R7
    {4'd7,  1'b1, 2'd2, 14'h058, 32'h0000_00F0, 32'h0},         // R7
    {4'd7,  1'b0, 2'd2, 14'h058, 32'h0,         32'h0F0F_0FFF}, // R7
    {4'd8,  1'b0, 2'd2, 14'h058, 32'h0,         32'h0F0F_0FFF}, // R8
    {4'd8,  1'b1, 2'd2, 14'h058, 32'hF0F0_F000, 32'h0},         // R8
    {4'd8,  1'b0, 2'd2, 14'h058, 32'h0,         32'hFFFF_FFFF}, // R8
    {4'd8,  1'b0, 2'd2, 14'h058, 32'h0,         32'h0},         // R8
    {4'd7,  1'b1, 2'd0, 14'h059, 32'h0000_0080, 32'h0},         // R7
    {4'd7,  1'b0, 2'd2, 14'h058, 32'h0,         32'h0000_8000}, // R7
    {4'd12, 1'b1, 2'd2, 14'h018, 32'h1357_9BDF, 32'h0},         // R12
    {4'd12, 1'b0, 2'd2, 14'h018, 32'h0,         32'h1357_9BDF}  // R12
  };

  task automatic check(input int req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL R%0d %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic op(input logic w, input logic [1:0] sz, input logic [AW-1:0] a,
                    input logic [31:0] d, output logic [31:0] rdat, output logic rv);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_size = sz; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    rdat = rsp_rdata; rv = rsp_valid;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic        v;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < N; i++) begin
      op(VEC[i][80], VEC[i][79:78], VEC[i][77:64], VEC[i][63:32], r, v);
      if (!VEC[i][80]) check(int'(VEC[i][84:81]), $sformatf("vector %0d", i), r, VEC[i][31:0]);
    end

    // R2: response timing and write response data
    op(1'b1, 2'd2, 14'h020, 32'h0BAD_F00D, r, v);
    check(2, "valid after write", {31'b0, v}, 32'h1);
    check(2, "rdata on write", r, 32'h0);
    @(negedge clk);
    check(2, "valid when idle", {31'b0, rsp_valid}, 32'h0);

    // R3: size code 3 behaves as word, lane bits ignored
    op(1'b1, 2'd3, 14'h022, 32'h7654_3210, r, v);
    op(1'b0, 2'd2, 14'h020, 32'h0, r, v);
    check(3, "size 3 word write", r, 32'h7654_3210);
    op(1'b0, 2'd3, 14'h023, 32'h0, r, v);
    check(3, "size 3 word read", r, 32'h7654_3210);

    // R6: odd word slot inside the array is a hole
    op(1'b1, 2'd2, 14'h104, 32'hFFFF_FFFF, r, v);
    op(1'b0, 2'd2, 14'h100, 32'h0, r, v);
    check(6, "neighbour of hole", r, 32'h1111_1111);

    // R1: reset mid-run restores values
    op(1'b1, 2'd2, 14'h058, 32'h0000_0001, r, v);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    op(1'b0, 2'd2, 14'h000, 32'h0, r, v);
    check(1, "config after reset", r, 32'h0000_0104);
    op(1'b0, 2'd2, 14'h078, 32'h0, r, v);
    check(1, "speed after reset", r, 32'h0000_0007);
    op(1'b0, 2'd2, 14'h058, 32'h0, r, v);
    check(1, "mask after reset", r, 32'h0);
    op(1'b0, 2'd2, 14'h1F8, 32'h0, r, v);
    check(1, "descriptor after reset", r, 32'h0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule